// File: doc/BRIEF.md
# Iterative CORDIC Polar Converter

This block turns a signed Cartesian sample pair into polar form, or a polar pair back into Cartesian form. One shift-and-add datapath does one micro-rotation per clock. A counter steps through the iterations and also addresses a small table of arctangent constants. In vectoring mode, `in_a`/`in_b` carry I and Q, and the block returns magnitude and phase. The phase is the quantity an FM discriminator differentiates. In rotation mode, `in_a`/`in_b` carry magnitude and phase, and the block returns I and Q.

The sample rates this block serves are far below the clock rate, so the datapath is iterated rather than unrolled. One sample is in flight at a time. A sample is taken with a valid/ready handshake while the block is idle. The result appears with a one-cycle done strobe. After the last iteration, a constant multiply by the inverse CORDIC gain removes the scaling that the micro-rotations add. The iteration count is a build-time parameter and sets the precision.

Phase uses a binary-angle code. The value is two's complement, and a full-scale 32768 stands for π, so +π and −π share the code −32768.

Top module: `cordic_polar`

## Requirements
- R1: With `in_mode`=0 (vectoring), `out_a` equals sqrt(I²+Q²) within ±8 LSB. `out_b` equals atan2(Q,I)·32768/π, compared modulo 2^16, within ±10 LSB. I is `in_a` and Q is `in_b`.
- R2: R1 holds in all four quadrants, including I<0 and the negative real axis. Before iterating, the block pre-rotates by ±90° when I is negative.
- R3: With `in_mode`=1 (rotation), `in_a` is a magnitude M in 0..32767 and `in_b` is a phase code P. `out_a` equals M·cos(P·π/32768) within ±8 LSB, and `out_b` equals M·sin(P·π/32768) within ±8 LSB.
- R4: In vectoring mode, I=Q=0 gives exactly `out_a`=0 and `out_b`=0.
- R5: Results saturate to the signed output range. For example, I=Q=−32768 gives `out_a`=32767 exactly, with the phase still within R1's tolerance of −24576.
- R6: `out_done` is high for exactly one cycle. It is first seen ITER+1 clock edges after the edge that accepted the sample, which is 17 edges for the default ITER=16.
- R7: `in_ready` is high exactly when the block is idle. It goes low on the edge after acceptance and comes back high together with `out_done`. `in_valid` and input data offered while busy are ignored and leave the result unchanged.
- R8: `out_a` and `out_b` change only on the edge that raises `out_done`, and they hold their values until the next result.
- R9: After reset, `in_ready`=1, `out_done`=0, `out_a`=0 and `out_b`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_mode | input | 1 | 0 = vectoring (I/Q to magnitude/phase), 1 = rotation (magnitude/phase to I/Q) |
| in_a | input | DATA_W | I (vectoring) or magnitude (rotation), signed |
| in_b | input | DATA_W | Q (vectoring) or phase code (rotation), signed |
| in_ready | output | 1 | Block idle and able to take a sample |
| out_done | output | 1 | One-cycle strobe: result registers updated |
| out_a | output | DATA_W | Magnitude (vectoring) or I (rotation) |
| out_b | output | DATA_W | Phase code (vectoring) or Q (rotation) |

## Verification
The sample is accepted on an edge. After that, `in_ready` must be low at the next falling edge, and `out_done` must stay low for the following ITER falling edges. `out_done` must be seen high on the falling edge after the (ITER+1)th edge, and be low again one cycle later with the results unchanged. Each scenario task counts falling edges from the one where it raised `in_valid` and samples the outputs exactly at the falling edge where the strobe is due. The checker bound to the top counts edges from acceptance independently, so a done strobe one cycle early or late, or a repeated strobe, is caught both by the bench and by the checker.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_SCALE = 2'd2
   } cordic_state_e;

   localparam real C_PI = 3.14159265358979323846;

   // binary-angle code of atan(2^-step), full scale 2^(ang_w-1) = pi
   function automatic longint atan_code(input int step, input int ang_w);
      real r;
      r = $atan(2.0 ** (-step)) * (2.0 ** (ang_w - 1)) / C_PI;
      return longint'(r);
   endfunction

   // 1/K for a given iteration count, as an unsigned fraction of frac_w bits
   function automatic longint inv_gain_code(input int iters, input int frac_w);
      real k;
      k = 1.0;
      for (int i = 0; i < iters; i++) begin
         k = k / $sqrt(1.0 + 2.0 ** (-2 * i));
      end
      return longint'(k * (2.0 ** frac_w));
   endfunction

endpackage

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom
   import cordic_pkg::*;
#(
   parameter int unsigned ITER  = 16,
   parameter int unsigned ANG_W = 16,
   parameter int unsigned IDX_W = 4
) (
   input  logic [IDX_W-1:0]        idx,
   output logic signed [ANG_W-1:0] angle
);

   logic signed [ANG_W-1:0] tbl [ITER];

   for (genvar g = 0; g < ITER; g++) begin : g_ent
      localparam longint CODE = atan_code(g, ANG_W);
      assign tbl[g] = ANG_W'(CODE);
   end

   assign angle = tbl[idx];

endmodule

// File: rtl/cordic_prerot.sv
module cordic_prerot #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned FRAC   = 2,
   parameter int unsigned XW     = 20
) (
   input  logic                     mode_rot,
   input  logic signed [DATA_W-1:0] a_i,
   input  logic signed [DATA_W-1:0] b_i,
   output logic signed [XW-1:0]     x_o,
   output logic signed [XW-1:0]     y_o,
   output logic signed [DATA_W-1:0] z_o,
   output logic                     zero_o
);

   localparam logic signed [DATA_W-1:0] QUARTER = {2'b01, {(DATA_W-2){1'b0}}};
   localparam int unsigned EXT = XW - DATA_W - FRAC;

   logic signed [XW-1:0] ax, bx;

   assign ax = {{EXT{a_i[DATA_W-1]}}, a_i, {FRAC{1'b0}}};
   assign bx = {{EXT{b_i[DATA_W-1]}}, b_i, {FRAC{1'b0}}};

   always_comb begin
      x_o = ax;
      y_o = bx;
      z_o = '0;
      if (!mode_rot) begin
         // vectoring: fold the left half-plane onto the right one
         if (a_i[DATA_W-1]) begin
            if (!b_i[DATA_W-1]) begin
               x_o = bx;
               y_o = -ax;
               z_o = QUARTER;
            end else begin
               x_o = -bx;
               y_o = ax;
               z_o = -QUARTER;
            end
         end
      end else begin
         // rotation: start on the real axis, bring |angle| under 90 degrees
         y_o = '0;
         z_o = b_i;
         unique case (b_i[DATA_W-1 -: 2])
            2'b01: begin
               x_o = '0;
               y_o = ax;
               z_o = b_i - QUARTER;
            end
            2'b10: begin
               x_o = '0;
               y_o = -ax;
               z_o = b_i + QUARTER;
            end
            default: ;
         endcase
      end
   end

   assign zero_o = !mode_rot && (a_i == '0) && (b_i == '0);

endmodule

// File: rtl/cordic_step.sv
module cordic_step #(
   parameter int unsigned XW    = 20,
   parameter int unsigned ANG_W = 16,
   parameter int unsigned SH_W  = 4
) (
   input  logic                    mode_rot,
   input  logic [SH_W-1:0]         shift,
   input  logic signed [ANG_W-1:0] angle,
   input  logic signed [XW-1:0]    x_i,
   input  logic signed [XW-1:0]    y_i,
   input  logic signed [ANG_W-1:0] z_i,
   output logic signed [XW-1:0]    x_o,
   output logic signed [XW-1:0]    y_o,
   output logic signed [ANG_W-1:0] z_o
);

   logic signed [XW-1:0] xs, ys;
   logic                 cw;

   assign xs = x_i >>> shift;
   assign ys = y_i >>> shift;
   // clockwise step: residual angle negative (rotation) or Q non-negative (vectoring)
   assign cw = mode_rot ? z_i[ANG_W-1] : ~y_i[XW-1];

   always_comb begin
      if (cw) begin
         x_o = x_i + ys;
         y_o = y_i - xs;
         z_o = z_i + angle;
      end else begin
         x_o = x_i - ys;
         y_o = y_i + xs;
         z_o = z_i - angle;
      end
   end

endmodule

// File: rtl/cordic_gain.sv
module cordic_gain
   import cordic_pkg::*;
#(
   parameter int unsigned XW     = 20,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ITER   = 16,
   parameter int unsigned KF     = 17,
   parameter int unsigned FRAC   = 2,
   parameter bit          ROUND  = 1'b1
) (
   input  logic signed [XW-1:0]     x_i,
   output logic signed [DATA_W-1:0] y_o
);

   localparam longint      KCODE = inv_gain_code(ITER, KF);
   localparam int unsigned PW    = XW + KF + 1;
   localparam int unsigned SH    = KF + FRAC;
   localparam logic signed [PW-1:0] HALF = PW'(1) << (SH - 1);
   localparam logic signed [PW-1:0] MAXP = PW'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
   localparam logic signed [PW-1:0] MINP = -MAXP - PW'(1);

   logic signed [KF:0]   kinv;
   logic signed [PW-1:0] xe, ke, prod, adj, shd;

   assign kinv = (KF+1)'(KCODE);
   assign xe   = {{(KF+1){x_i[XW-1]}}, x_i};
   assign ke   = {{XW{1'b0}}, kinv};
   assign prod = xe * ke;

   if (ROUND) begin : g_round
      assign adj = prod + HALF;
   end else begin : g_trunc
      assign adj = prod;
   end

   assign shd = adj >>> SH;

   always_comb begin
      if (shd > MAXP)      y_o = DATA_W'(MAXP);
      else if (shd < MINP) y_o = DATA_W'(MINP);
      else                 y_o = shd[DATA_W-1:0];
   end

endmodule

// File: rtl/cordic_polar.sv
module cordic_polar
   import cordic_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ITER   = 16,
   parameter int unsigned FRAC   = 2,
   parameter int unsigned KF     = 17,
   parameter bit          ROUND  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     in_mode,
   input  logic signed [DATA_W-1:0] in_a,
   input  logic signed [DATA_W-1:0] in_b,
   output logic                     in_ready,
   output logic                     out_done,
   output logic signed [DATA_W-1:0] out_a,
   output logic signed [DATA_W-1:0] out_b
);

   localparam int unsigned XW   = DATA_W + 2 + FRAC;
   localparam int unsigned CW   = $clog2(ITER);
   localparam logic [CW-1:0] LAST = CW'(ITER - 1);

   if (DATA_W < 8) begin : g_chk_dw
      $error("cordic_polar: DATA_W must be at least 8");
   end
   if (ITER < 4 || ITER > DATA_W + 2) begin : g_chk_it
      $error("cordic_polar: ITER out of range 4..DATA_W+2");
   end
   if (FRAC < 1 || FRAC > 8) begin : g_chk_fr
      $error("cordic_polar: FRAC out of range 1..8");
   end
   if (KF < 8 || KF > 30) begin : g_chk_kf
      $error("cordic_polar: KF out of range 8..30");
   end

   cordic_state_e        state_q;
   logic signed [XW-1:0] x_q, y_q, px, py, nx, ny;
   logic signed [DATA_W-1:0] z_q, pz, nz, ang, ga, gb;
   logic [CW-1:0]        cnt_q;
   logic                 mode_q, zero_q, pzero;

   cordic_prerot #(.DATA_W(DATA_W), .FRAC(FRAC), .XW(XW)) u_pre (
      .mode_rot (in_mode),
      .a_i      (in_a),
      .b_i      (in_b),
      .x_o      (px),
      .y_o      (py),
      .z_o      (pz),
      .zero_o   (pzero)
   );

   cordic_atan_rom #(.ITER(ITER), .ANG_W(DATA_W), .IDX_W(CW)) u_rom (
      .idx   (cnt_q),
      .angle (ang)
   );

   cordic_step #(.XW(XW), .ANG_W(DATA_W), .SH_W(CW)) u_step (
      .mode_rot (mode_q),
      .shift    (cnt_q),
      .angle    (ang),
      .x_i      (x_q),
      .y_i      (y_q),
      .z_i      (z_q),
      .x_o      (nx),
      .y_o      (ny),
      .z_o      (nz)
   );

   cordic_gain #(.XW(XW), .DATA_W(DATA_W), .ITER(ITER), .KF(KF), .FRAC(FRAC),
                 .ROUND(ROUND)) u_gain_a (
      .x_i (x_q),
      .y_o (ga)
   );

   cordic_gain #(.XW(XW), .DATA_W(DATA_W), .ITER(ITER), .KF(KF), .FRAC(FRAC),
                 .ROUND(ROUND)) u_gain_b (
      .x_i (y_q),
      .y_o (gb)
   );

   assign in_ready = (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         x_q      <= '0;
         y_q      <= '0;
         z_q      <= '0;
         cnt_q    <= '0;
         mode_q   <= 1'b0;
         zero_q   <= 1'b0;
         out_done <= 1'b0;
         out_a    <= '0;
         out_b    <= '0;
      end else begin
         out_done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (in_valid) begin
                  x_q     <= px;
                  y_q     <= py;
                  z_q     <= pz;
                  mode_q  <= in_mode;
                  zero_q  <= pzero;
                  cnt_q   <= '0;
                  state_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               x_q <= nx;
               y_q <= ny;
               z_q <= nz;
               if (cnt_q == LAST) begin
                  state_q <= ST_SCALE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_SCALE: begin
               out_a    <= ga;
               out_b    <= mode_q ? gb : (zero_q ? '0 : z_q);
               out_done <= 1'b1;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cordic_polar_chk.sv
module cordic_polar_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ITER   = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic                     in_ready,
   input logic                     out_done,
   input logic signed [DATA_W-1:0] out_a,
   input logic signed [DATA_W-1:0] out_b
);

   localparam int unsigned DUE = ITER + 2;
   localparam int unsigned LW  = $clog2(ITER + 4);

   logic [LW-1:0] lat_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                  lat_q <= '0;
      else if (in_valid && in_ready) lat_q <= LW'(1);
      else if (out_done)           lat_q <= '0;
      else if (lat_q != '0)        lat_q <= lat_q + 1'b1;
   end

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |=> !out_done);

   a_r6_done_when_due: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q == LW'(DUE)) |-> out_done);

   a_r6_done_only_due: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> (lat_q == LW'(DUE)));

   a_r7_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   a_r7_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> in_ready);

   a_r8_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
      !out_done |-> ($stable(out_a) && $stable(out_b)));

endmodule

bind cordic_polar cordic_polar_chk #(.DATA_W(DATA_W), .ITER(ITER)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .out_done (out_done),
   .out_a    (out_a),
   .out_b    (out_b)
);

// File: tb/sim_cordic_polar.sv
`timescale 1ns/1ps
module sim_cordic_polar;

   localparam int DW  = 16;
   localparam int IT  = 16;
   localparam int DUE = IT + 2;        // falling edges after the one raising in_valid
   localparam real PI = 3.14159265358979323846;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_mode = 1'b0;
   logic signed [DW-1:0] in_a = '0;
   logic signed [DW-1:0] in_b = '0;
   logic in_ready, out_done;
   logic signed [DW-1:0] out_a, out_b;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   cordic_polar #(.DATA_W(DW), .ITER(IT)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
      .in_a(in_a), .in_b(in_b), .in_ready(in_ready), .out_done(out_done),
      .out_a(out_a), .out_b(out_b)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int absi(input int v);
      return (v < 0) ? -v : v;
   endfunction

   // one operation with handshake and timing checks (R6, R7, R8)
   task automatic run_op(input bit mode, input int a, input int b, input bit poke,
                         output int ga, output int gb);
      int early;
      @(negedge clk);
      in_valid = 1'b1; in_mode = mode; in_a = DW'(a); in_b = DW'(b);
      @(negedge clk);
      chk(in_ready == 1'b0, "R7", "ready low after accept", in_ready, 0);
      if (poke) begin
         in_valid = 1'b1; in_mode = ~mode; in_a = DW'(a ^ 16'h5a5a); in_b = DW'(~b);
      end else begin
         in_valid = 1'b0;
      end
      early = 0;
      for (int k = 2; k < DUE; k++) begin
         @(negedge clk);
         if (out_done || in_ready) early++;
      end
      chk(early == 0, "R6", "no done/ready before due", early, 0);
      @(negedge clk);
      chk(out_done == 1'b1, "R6", "done at due cycle", out_done, 1);
      chk(in_ready == 1'b1, "R7", "ready with done", in_ready, 1);
      ga = out_a; gb = out_b;
      in_valid = 1'b0;
      @(negedge clk);
      chk(out_done == 1'b0, "R6", "done one cycle only", out_done, 0);
      chk(out_a == ga && out_b == gb, "R8", "results hold", out_a, ga);
   endtask

   task automatic t_vec(input int i, input int q, input string req, input bit poke);
      int ga, gb, em, ep;
      real m;
      logic signed [DW-1:0] dph;
      run_op(1'b0, i, q, poke, ga, gb);
      m  = $sqrt(real'(i) * real'(i) + real'(q) * real'(q));
      em = (m > 32767.0) ? 32767 : int'(m);
      ep = int'($atan2(real'(q), real'(i)) * 32768.0 / PI);
      dph = DW'(gb - ep);
      chk(absi(ga - em) <= 8, req, "magnitude", ga, em);
      chk(absi(int'(dph)) <= 10, req, "phase", gb, ep);
   endtask

   task automatic t_rot(input int m, input int p);
      int ga, gb, ei, eq;
      real ang;
      run_op(1'b1, m, p, 1'b0, ga, gb);
      ang = real'(p) * PI / 32768.0;
      ei = int'(real'(m) * $cos(ang));
      eq = int'(real'(m) * $sin(ang));
      chk(absi(ga - ei) <= 8, "R3", "rotation I", ga, ei);
      chk(absi(gb - eq) <= 8, "R3", "rotation Q", gb, eq);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      chk(in_ready == 1'b1, "R9", "reset ready", in_ready, 1);
      chk(out_done == 1'b0, "R9", "reset done", out_done, 0);
      chk(out_a == 0 && out_b == 0, "R9", "reset outputs", out_a, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_zero();
      int ga, gb;
      run_op(1'b0, 0, 0, 1'b0, ga, gb);
      chk(ga == 0, "R4", "zero magnitude", ga, 0);
      chk(gb == 0, "R4", "zero phase", gb, 0);
   endtask

   task automatic t_saturate();
      int ga, gb;
      logic signed [DW-1:0] dph;
      run_op(1'b0, -32768, -32768, 1'b0, ga, gb);
      dph = DW'(gb + 24576);
      chk(ga == 32767, "R5", "saturated magnitude", ga, 32767);
      chk(absi(int'(dph)) <= 10, "R5", "phase at saturation", gb, -24576);
      run_op(1'b0, 32767, 32767, 1'b0, ga, gb);
      chk(ga == 32767, "R5", "saturated magnitude q1", ga, 32767);
   endtask

   initial begin
      t_reset();
      t_vec(20000, 10000, "R1", 1'b0);
      t_vec(1000, 25000, "R1", 1'b0);
      t_vec(30000, -5000, "R1", 1'b0);
      t_vec(12345, 0, "R1", 1'b0);
      t_vec(-20000, 5000, "R2", 1'b0);
      t_vec(-8000, -30000, "R2", 1'b0);
      t_vec(-30000, 0, "R2", 1'b0);
      t_vec(0, -20000, "R2", 1'b0);
      t_zero();
      t_saturate();
      t_rot(20000, 0);
      t_rot(20000, 8192);
      t_rot(15000, 20000);
      t_rot(25000, -30000);
      t_rot(30000, -32768);
      t_rot(32767, -12000);
      // R7: input offered while busy must not disturb the running result
      t_vec(-15000, 22000, "R7", 1'b1);
      repeat (3) @(negedge clk);
      chk(out_done == 1'b0, "R7", "no extra result after busy offers", out_done, 0);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R6 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule